// File: doc/BRIEF.md
# Double-to-fixed saturating converter

The block converts one 64-bit IEEE double-precision operand into a 32-bit result. The result takes one of two forms. The first is a signed two's-complement integer, always truncated toward zero. The second is an unsigned fraction that represents the value times 2^32, rounded with a 2-bit rounding mode. A result that falls outside the target range saturates. Along with the result, the unit reports invalid, inexact, guard and sticky flags and a destination write-enable. Two enable inputs, one for invalid and one for inexact, shape that write-enable and the written value.

An operation starts with a one-cycle `issue` pulse. The pulse carries three instruction fields: the primary opcode, a field that must be zero, and the extended opcode. The operand, the rounding mode and both enables are captured on the same edge. A small controller has three states. `ST_IDLE` is the quiet state. In `ST_CONV` a recognised conversion is presented. In `ST_SKIP` an unrecognised word is answered with no write. The transitions are `ST_IDLE`/`ST_CONV`/`ST_SKIP` → `ST_CONV` on an issue of a recognised word, → `ST_SKIP` on an issue of any other word, and → `ST_IDLE` when no issue is present. Every result is therefore shown for exactly the one cycle after its issue. Back-to-back issues are allowed.

The operand is split into sign, exponent and mantissa and then classified. A normal value is aligned by one right shift that keeps the first dropped bit and the OR of all lower dropped bits. A rounding and saturation stage then forms the final word and the flags.

Top module: `dbl_fix_cvt`

## Requirements
- R1: `done` is 1 in the cycle after every `issue` edge and 0 otherwise. While `done` is 0, the outputs `wr_en`, `result`, `invalid`, `inexact`, `guard` and `sticky` are all 0. The operand and the modes are captured at issue, so changing them afterwards does not alter the presented result.
- R2: A word is recognised only when all of the following hold: `prim_op` is 6'b000100, `rsvd_fld` is 0, and `ext_op` is 11'h2FA (signed integer) or 11'h2F6 (unsigned fraction). Any other word gives `done`=1 with `wr_en`, `result` and every flag at 0.
- R3: In signed-integer mode the result is the value truncated toward zero, whatever `rmode` holds.
- R4: In fraction mode the result is value×2^32, rounded by `rmode`: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. For example, 0.5 gives 0x80000000.
- R5: When a result does not fit, it saturates and `invalid` is raised. In integer mode the limits are 0x7FFFFFFF and 0x80000000. In fraction mode a rounded value at or above 2^32 gives 0xFFFFFFFF, and a negative value with a nonzero rounded magnitude gives 0x00000000. A negative fraction that rounds to zero is written as 0 and is not invalid.
- R6: A NaN or a denormal operand gives result 0 with `invalid`. An infinity gives `invalid` and saturates by its sign.
- R7: Whenever `invalid` is 1, `guard`, `sticky` and `inexact` are 0.
- R8: When `invalid` is raised and the captured `inv_en` is 1, `wr_en` is 0 and `result` is 0. Otherwise a recognised conversion has `wr_en`=1.
- R9: `inexact` is raised when a valid conversion discards nonzero bits. Signed or unsigned zero converts to 0 with no flag.
- R10: For a valid conversion, `guard` is the first bit below the truncation point and `sticky` is the OR of all lower bits. When `inexact` and the captured `inx_en` are both 1, the written value is the truncated magnitude, not the rounded one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Start one operation |
| prim_op | input | 6 | Primary opcode field |
| rsvd_fld | input | 5 | Field that must be zero |
| ext_op | input | 11 | Extended opcode field, selects mode |
| opnd | input | 64 | Double-precision operand |
| rmode | input | 2 | Rounding mode for fraction mode |
| inv_en | input | 1 | Invalid-exception enable |
| inx_en | input | 1 | Inexact-exception enable |
| done | output | 1 | Result presented this cycle |
| wr_en | output | 1 | Destination write-enable |
| result | output | 32 | Converted value |
| invalid | output | 1 | Invalid flag |
| inexact | output | 1 | Inexact flag |
| guard | output | 1 | First discarded bit |
| sticky | output | 1 | OR of lower discarded bits |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and a 32-bit result. With these values every vector is an ordinary double encoding, and the table can reach the exact alignment edges. These edges are a shift of 53 places, where only the guard bit survives; shifts past that, where only the sticky bit survives; and operands whose exponent is large enough to bypass the shifter. The same parameters put the saturation edges within reach: 2^31−1, 2^31 and −2^31 in integer mode, and values just under 1.0 that round up to 2^32 in fraction mode.

// File: rtl/dbl_fix_pkg.sv
package dbl_fix_pkg;

    localparam int OPND_W = 64;
    localparam int RES_W  = 32;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;

    localparam logic [5:0]  PRIMARY_OP = 6'b000100;
    localparam logic [10:0] XO_SINT    = 11'h2FA;
    localparam logic [10:0] XO_UFRAC   = 11'h2F6;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } opnd_cls_e;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_ZERO      = 2'b01,
        RM_POS_INF   = 2'b10,
        RM_NEG_INF   = 2'b11
    } rmode_e;

    typedef enum logic {
        CV_SINT  = 1'b0,
        CV_UFRAC = 1'b1
    } cvt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_SKIP
    } fsm_state_e;

endpackage

// File: rtl/dbl_fix_decode.sv
module dbl_fix_decode
    import dbl_fix_pkg::*;
(
    input  logic [5:0]  prim_op,
    input  logic [4:0]  rsvd_fld,
    input  logic [10:0] ext_op,
    output logic        legal,
    output cvt_kind_e   kind
);

    logic frame_ok;

    always_comb begin
        frame_ok = (prim_op == PRIMARY_OP) && (rsvd_fld == '0);
        legal    = 1'b0;
        kind     = CV_SINT;
        if (frame_ok) begin
            unique case (ext_op)
                XO_SINT: begin
                    legal = 1'b1;
                    kind  = CV_SINT;
                end
                XO_UFRAC: begin
                    legal = 1'b1;
                    kind  = CV_UFRAC;
                end
                default: begin
                    legal = 1'b0;
                    kind  = CV_SINT;
                end
            endcase
        end
    end

endmodule

// File: rtl/dbl_fix_align.sv
module dbl_fix_align
    import dbl_fix_pkg::*;
#(
    parameter int P_OPND_W = OPND_W,
    parameter int P_EXP_W  = EXP_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_RES_W  = RES_W
) (
    input  logic [P_OPND_W-1:0] opnd,
    input  cvt_kind_e           kind,
    output opnd_cls_e           cls,
    output logic                sign,
    output logic [P_FRAC_W:0]   mag,
    output logic                guard,
    output logic                sticky,
    output logic                big
);

    localparam int MANT_W     = P_FRAC_W + 1;
    localparam int EXT_W      = 2 * MANT_W;
    localparam int SH_W       = P_EXP_W + 1;
    localparam int IDX_W      = $clog2(EXT_W);
    localparam int BIAS       = (1 << (P_EXP_W - 1)) - 1;
    localparam int INT_BASE   = BIAS + P_FRAC_W;
    localparam int FRAC_BASE  = INT_BASE - P_RES_W;

    logic [P_EXP_W-1:0]  expo;
    logic [P_FRAC_W-1:0] frac;
    logic [SH_W-1:0]     expo_ext;
    logic [SH_W-1:0]     base;
    logic [SH_W-1:0]     rsh;
    logic                far;
    logic [EXT_W-1:0]    ext;
    logic [EXT_W-1:0]    shifted;

    assign sign     = opnd[P_OPND_W-1];
    assign expo     = opnd[P_OPND_W-2 -: P_EXP_W];
    assign frac     = opnd[P_FRAC_W-1:0];
    assign expo_ext = {1'b0, expo};

    always_comb begin
        if (expo == '0)
            cls = (frac == '0) ? CLS_ZERO : CLS_DENORM;
        else if (expo == '1)
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_NORMAL;
    end

    assign base = (kind == CV_UFRAC) ? SH_W'(FRAC_BASE) : SH_W'(INT_BASE);
    assign big  = (expo_ext >= base);
    assign rsh  = base - expo_ext;
    assign far  = !big && (rsh > SH_W'(MANT_W));

    assign ext     = {1'b1, frac, {MANT_W{1'b0}}};
    assign shifted = ext >> rsh[IDX_W-1:0];

    always_comb begin
        if (big) begin
            mag    = '0;
            guard  = 1'b0;
            sticky = 1'b0;
        end else if (far) begin
            mag    = '0;
            guard  = 1'b0;
            sticky = 1'b1;
        end else begin
            mag    = shifted[EXT_W-1 -: MANT_W];
            guard  = shifted[MANT_W-1];
            sticky = |shifted[MANT_W-2:0];
        end
    end

endmodule

// File: rtl/dbl_fix_round.sv
module dbl_fix_round
    import dbl_fix_pkg::*;
#(
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_RES_W  = RES_W
) (
    input  opnd_cls_e           cls,
    input  logic                sign,
    input  cvt_kind_e           kind,
    input  logic [1:0]          rmode,
    input  logic [P_FRAC_W:0]   mag,
    input  logic                guard_in,
    input  logic                sticky_in,
    input  logic                big,
    input  logic                inx_en,
    output logic [P_RES_W-1:0]  res,
    output logic                invalid,
    output logic                inexact,
    output logic                guard,
    output logic                sticky
);

    localparam int MANT_W = P_FRAC_W + 1;
    localparam logic [MANT_W-1:0] SINT_POS_MAX = MANT_W'((64'd1 << (P_RES_W - 1)) - 64'd1);
    localparam logic [MANT_W-1:0] SINT_NEG_MAX = MANT_W'(64'd1 << (P_RES_W - 1));
    localparam logic [MANT_W:0]   UFRAC_MAX    = (MANT_W+1)'((64'd1 << P_RES_W) - 64'd1);
    localparam logic [P_RES_W-1:0] SAT_POS     = {1'b0, {(P_RES_W-1){1'b1}}};
    localparam logic [P_RES_W-1:0] SAT_NEG     = {1'b1, {(P_RES_W-1){1'b0}}};

    logic               lost;
    logic               inc;
    logic [MANT_W:0]    rmag;
    logic               ovf;
    logic [P_RES_W-1:0] sat_val;
    logic [P_RES_W-1:0] fit_val;

    assign lost = guard_in | sticky_in;

    always_comb begin
        inc = 1'b0;
        if (kind == CV_UFRAC) begin
            unique case (rmode_e'(rmode))
                RM_NEAR_EVEN: inc = guard_in & (sticky_in | mag[0]);
                RM_ZERO:      inc = 1'b0;
                RM_POS_INF:   inc = !sign & lost;
                RM_NEG_INF:   inc = sign & lost;
                default:      inc = 1'b0;
            endcase
        end
    end

    assign rmag = {1'b0, mag} + {{MANT_W{1'b0}}, inc};

    always_comb begin
        if (kind == CV_SINT) begin
            ovf     = big || (!sign && (mag > SINT_POS_MAX)) || (sign && (mag > SINT_NEG_MAX));
            sat_val = sign ? SAT_NEG : SAT_POS;
            fit_val = sign ? (~mag[P_RES_W-1:0] + 1'b1) : mag[P_RES_W-1:0];
        end else begin
            ovf     = big || (!sign && (rmag > UFRAC_MAX)) || (sign && (rmag != '0));
            sat_val = sign ? '0 : '1;
            fit_val = (lost && inx_en) ? mag[P_RES_W-1:0] : rmag[P_RES_W-1:0];
        end
    end

    always_comb begin
        res     = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        guard   = 1'b0;
        sticky  = 1'b0;
        case (cls)
            CLS_ZERO: begin
                res = '0;
            end
            CLS_NORMAL: begin
                if (ovf) begin
                    invalid = 1'b1;
                    res     = sat_val;
                end else begin
                    res     = fit_val;
                    inexact = lost;
                    guard   = guard_in;
                    sticky  = sticky_in;
                end
            end
            CLS_INF: begin
                invalid = 1'b1;
                res     = sat_val;
            end
            default: begin
                invalid = 1'b1;
                res     = '0;
            end
        endcase
    end

endmodule

// File: rtl/dbl_fix_cvt.sv
module dbl_fix_cvt
    import dbl_fix_pkg::*;
#(
    parameter int P_OPND_W = OPND_W,
    parameter int P_EXP_W  = EXP_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_RES_W  = RES_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [5:0]          prim_op,
    input  logic [4:0]          rsvd_fld,
    input  logic [10:0]         ext_op,
    input  logic [P_OPND_W-1:0] opnd,
    input  logic [1:0]          rmode,
    input  logic                inv_en,
    input  logic                inx_en,
    output logic                done,
    output logic                wr_en,
    output logic [P_RES_W-1:0]  result,
    output logic                invalid,
    output logic                inexact,
    output logic                guard,
    output logic                sticky
);

    fsm_state_e          state, state_nx;
    logic                legal;
    cvt_kind_e           kind_dec;
    logic [P_OPND_W-1:0] opnd_q;
    cvt_kind_e           kind_q;
    logic [1:0]          rm_q;
    logic                inv_en_q;
    logic                inx_en_q;

    opnd_cls_e           a_cls;
    logic                a_sign;
    logic [P_FRAC_W:0]   a_mag;
    logic                a_guard;
    logic                a_sticky;
    logic                a_big;

    logic [P_RES_W-1:0]  c_res;
    logic                c_inv;
    logic                c_inx;
    logic                c_guard;
    logic                c_sticky;

    dbl_fix_decode u_decode (
        .prim_op  (prim_op),
        .rsvd_fld (rsvd_fld),
        .ext_op   (ext_op),
        .legal    (legal),
        .kind     (kind_dec)
    );

    dbl_fix_align #(
        .P_OPND_W (P_OPND_W),
        .P_EXP_W  (P_EXP_W),
        .P_FRAC_W (P_FRAC_W),
        .P_RES_W  (P_RES_W)
    ) u_align (
        .opnd   (opnd_q),
        .kind   (kind_q),
        .cls    (a_cls),
        .sign   (a_sign),
        .mag    (a_mag),
        .guard  (a_guard),
        .sticky (a_sticky),
        .big    (a_big)
    );

    dbl_fix_round #(
        .P_FRAC_W (P_FRAC_W),
        .P_RES_W  (P_RES_W)
    ) u_round (
        .cls       (a_cls),
        .sign      (a_sign),
        .kind      (kind_q),
        .rmode     (rm_q),
        .mag       (a_mag),
        .guard_in  (a_guard),
        .sticky_in (a_sticky),
        .big       (a_big),
        .inx_en    (inx_en_q),
        .res       (c_res),
        .invalid   (c_inv),
        .inexact   (c_inx),
        .guard     (c_guard),
        .sticky    (c_sticky)
    );

    always_comb begin
        unique case (state)
            ST_IDLE, ST_CONV, ST_SKIP: begin
                if (!issue)
                    state_nx = ST_IDLE;
                else if (legal)
                    state_nx = ST_CONV;
                else
                    state_nx = ST_SKIP;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            opnd_q   <= '0;
            kind_q   <= CV_SINT;
            rm_q     <= '0;
            inv_en_q <= 1'b0;
            inx_en_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (issue) begin
                opnd_q   <= opnd;
                kind_q   <= kind_dec;
                rm_q     <= rmode;
                inv_en_q <= inv_en;
                inx_en_q <= inx_en;
            end
        end
    end

    always_comb begin
        done    = 1'b0;
        wr_en   = 1'b0;
        result  = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        guard   = 1'b0;
        sticky  = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SKIP: begin
                done = 1'b1;
            end
            ST_CONV: begin
                done    = 1'b1;
                wr_en   = !(c_inv && inv_en_q);
                result  = wr_en ? c_res : '0;
                invalid = c_inv;
                inexact = c_inx;
                guard   = c_guard;
                sticky  = c_sticky;
            end
            default: begin
            end
        endcase
    end

    // R1: a result appears in the cycle after each issue
    assert_done_follows_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> done);

    // R1: quiet outputs whenever nothing is presented
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!wr_en && result == '0 && !invalid && !inexact && !guard && !sticky));

    // R2: an unrecognised word never writes
    assert_reject_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !legal) |=> (done && !wr_en && !invalid && result == '0));

    // R5: integer-mode saturation limits
    assert_sint_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid && wr_en && kind_q == CV_SINT) |->
            (result == {1'b0, {(P_RES_W-1){1'b1}}} || result == {1'b1, {(P_RES_W-1){1'b0}}} || result == '0));

    // R5: fraction-mode saturation limits
    assert_ufrac_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid && wr_en && kind_q == CV_UFRAC) |->
            (result == '1 || result == '0));

    // R7: invalid clears the other status bits
    assert_invalid_clears_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (!guard && !sticky && !inexact));

    // R8: enabled invalid blocks the write
    assert_invalid_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && inv_en) |=> !(invalid && wr_en));

    // R9: an exact result carries no discarded bits
    assert_exact_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_en && !inexact && !invalid) |-> (!guard && !sticky));

endmodule

// File: tb/test_dbl_fix_cvt.sv
module test_dbl_fix_cvt;

    logic        clk;
    logic        rst_n;
    logic        issue;
    logic [5:0]  prim_op;
    logic [4:0]  rsvd_fld;
    logic [10:0] ext_op;
    logic [63:0] opnd;
    logic [1:0]  rmode;
    logic        inv_en;
    logic        inx_en;
    logic        done;
    logic        wr_en;
    logic [31:0] result;
    logic        invalid;
    logic        inexact;
    logic        guard;
    logic        sticky;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    dbl_fix_cvt i_dbl_fix_cvt (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .prim_op  (prim_op),
        .rsvd_fld (rsvd_fld),
        .ext_op   (ext_op),
        .opnd     (opnd),
        .rmode    (rmode),
        .inv_en   (inv_en),
        .inx_en   (inx_en),
        .done     (done),
        .wr_en    (wr_en),
        .result   (result),
        .invalid  (invalid),
        .inexact  (inexact),
        .guard    (guard),
        .sticky   (sticky)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct packed {
        logic        frac;
        logic [1:0]  rm;
        logic        ie;
        logic        xe;
        logic [63:0] op;
        logic [31:0] res;
        logic        wr;
        logic        inv;
        logic        inx;
        logic        g;
        logic        st;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t TBL [NV] = '{
        // integer mode: R3 truncation, rounding mode ignored
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 32'h00000001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h3FF8000000000000, 32'h00000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},
        '{1'b0, 2'd2, 1'b0, 1'b0, 64'h4004000000000000, 32'h00000002, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},
        '{1'b0, 2'd3, 1'b0, 1'b0, 64'hBFF8000000000000, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'hC006000000000000, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd3},
        // R9 inexact below one
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h3FE8000000000000, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd9},
        // R5 integer limits
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h41DFFFFFFFC00000, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h41E0000000000000, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'hC1E0000000000000, 32'h80000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'hC1F0000000000000, 32'h80000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h7FE0000000000000, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
        // R9 tiny normal, zeros
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h0010000000000000, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd9},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h0000000000000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h8000000000000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},
        // R6 special operands
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h7FF0000000000000, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h7FF8000000000000, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h0000000000000001, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},
        // R8 enabled invalid
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'h7FF0000000000000, 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8},
        // R10 enabled inexact, integer
        '{1'b0, 2'd0, 1'b0, 1'b1, 64'h3FF8000000000000, 32'h00000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd10},
        // fraction mode: R4 rounding
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'h3FE0000000000000, 32'h80000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'h3DE0000000000000, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4},
        '{1'b1, 2'd2, 1'b0, 1'b0, 64'h3DE0000000000000, 32'h00000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4},
        '{1'b1, 2'd1, 1'b0, 1'b0, 64'h3DE8000000000000, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4},
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'h3DE8000000000000, 32'h00000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4},
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'h3DF8000000000000, 32'h00000002, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4},
        '{1'b1, 2'd3, 1'b0, 1'b0, 64'h3DF8000000000000, 32'h00000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4},
        // R5 fraction saturation
        '{1'b1, 2'd1, 1'b0, 1'b0, 64'h3FEFFFFFFFF00000, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd5},
        '{1'b1, 2'd2, 1'b0, 1'b0, 64'h3FEFFFFFFFF00000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'hBDE0000000000000, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd5},
        '{1'b1, 2'd3, 1'b0, 1'b0, 64'hBDE0000000000000, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
        // R6 negative infinity in fraction mode
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'hFFF0000000000000, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},
        // R10 enabled inexact writes truncated fraction
        '{1'b1, 2'd0, 1'b0, 1'b1, 64'h3DF8000000000000, 32'h00000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd10},
        // R8 enabled invalid on NaN, fraction mode
        '{1'b1, 2'd0, 1'b1, 1'b0, 64'h7FF8000000000000, 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8},
        // R7 overflow with inexact enabled keeps only invalid
        '{1'b1, 2'd2, 1'b0, 1'b1, 64'h3FEFFFFFFFF00000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7}
    };

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // packed observation: {done, wr, inv, inx, g, st, result}
    task automatic check(input string tag, input logic [37:0] exp_v);
        logic [37:0] got;
        got = {done, wr_en, invalid, inexact, guard, sticky, result};
        n_checks++;
        if (got !== exp_v) begin
            n_fails++;
            $display("FAIL %s: got done/wr/inv/inx/g/st=%b res=%h, expected %b res=%h",
                     tag, got[37:32], got[31:0], exp_v[37:32], exp_v[31:0]);
        end
    endtask

    task automatic drive(input logic [5:0] po, input logic [4:0] rz, input logic [10:0] xo,
                         input logic [63:0] op, input logic [1:0] rm,
                         input logic ie, input logic xe);
        issue    = 1'b1;
        prim_op  = po;
        rsvd_fld = rz;
        ext_op   = xo;
        opnd     = op;
        rmode    = rm;
        inv_en   = ie;
        inx_en   = xe;
        @(negedge clk);
        issue    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got running, expected finished");
        report();
    end

    initial begin
        issue    = 1'b0;
        prim_op  = '0;
        rsvd_fld = '0;
        ext_op   = '0;
        opnd     = '0;
        rmode    = '0;
        inv_en   = 1'b0;
        inx_en   = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 38'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 38'h0);

        for (int i = 0; i < NV; i++) begin
            drive(6'b000100, 5'd0, TBL[i].frac ? 11'h2F6 : 11'h2FA,
                  TBL[i].op, TBL[i].rm, TBL[i].ie, TBL[i].xe);
            check($sformatf("R%0d vector %0d", TBL[i].req, i),
                  {1'b1, TBL[i].wr, TBL[i].inv, TBL[i].inx, TBL[i].g, TBL[i].st, TBL[i].res});
        end

        // R1: done drops when no issue follows
        @(negedge clk);
        check("R1 done drops", 38'h0);

        // R1: operand change after capture has no effect on presented result
        issue    = 1'b1;
        prim_op  = 6'b000100;
        rsvd_fld = 5'd0;
        ext_op   = 11'h2FA;
        opnd     = 64'h4004000000000000;
        rmode    = 2'd0;
        inv_en   = 1'b0;
        inx_en   = 1'b0;
        @(posedge clk);
        #1;
        issue  = 1'b0;
        opnd   = 64'h7FF0000000000000;
        inv_en = 1'b1;
        @(negedge clk);
        check("R1 captured operand", {6'b110110, 32'h00000002});

        // R1: back-to-back issues each give their own result
        drive(6'b000100, 5'd0, 11'h2FA, 64'h3FF0000000000000, 2'd0, 1'b0, 1'b0);
        check("R1 back to back first", {6'b110000, 32'h00000001});
        drive(6'b000100, 5'd0, 11'h2F6, 64'h3FE0000000000000, 2'd0, 1'b0, 1'b0);
        check("R1 back to back second", {6'b110000, 32'h80000000});

        // R2: unrecognised words
        drive(6'b000101, 5'd0, 11'h2FA, 64'h3FF0000000000000, 2'd0, 1'b0, 1'b0);
        check("R2 wrong primary opcode", {6'b100000, 32'h0});
        drive(6'b000100, 5'd4, 11'h2FA, 64'h3FF0000000000000, 2'd0, 1'b0, 1'b0);
        check("R2 nonzero reserved field", {6'b100000, 32'h0});
        drive(6'b000100, 5'd0, 11'h2F8, 64'h7FF0000000000000, 2'd0, 1'b1, 1'b0);
        check("R2 unknown extended opcode", {6'b100000, 32'h0});
        @(negedge clk);
        check("R2 idle after reject", 38'h0);

        report();
    end

endmodule